// File: doc/BRIEF.md
# Event Queue Producer Controller

The block is the hardware side of a single circular event queue kept in a local memory. Each accepted event becomes a fixed 32-byte record written at the slot the producer index points to. Before it writes, the block checks the ownership flag of that slot, which the memory model presents on `own_i`. A slot may be written only while the hardware owns it, and every write hands the slot back to software by clearing the flag.

Software reports progress through 32-bit doorbell writes. A doorbell can advance the consumer index, set it outright, arm notification once or permanently, or ask for a completion-queue disarm. The block keeps a producer index, a consumer index and a fill count. It drops events that would overrun the consumer or land on a slot that software still holds, and it records the first such fault in a sticky status code. A notification state machine decides which accepted events raise the interrupt line.

Top module: `eq_producer`

## Requirements
- R1: After reset the producer index, consumer index, notification state (`arm_state_o`) and status all read 0, and `mem_we_o`, `irq_o` and `cq_disarm_vld_o` are low.
- R2: When an event is accepted, `mem_we_o` is high for one cycle in the following cycle and the producer index advances by one, modulo DEPTH. In that cycle `mem_addr_o` is the slot index times 32. `mem_wdata_o` carries the type in byte 1, the subtype in byte 3 and the payload in bytes 4 to 27. All other bytes are zero, including the ownership flag, which is bit 255 (byte 31, bit 7). Byte k occupies bits 8k+7:8k.
- R3: If `own_i` is 0 when an event arrives and the queue is not full, the event is dropped: nothing is written and the producer index does not move. A status that still reads 0 becomes 10 (write failure).
- R4: If DEPTH entries are outstanding when an event arrives, the event is dropped: nothing is written and the producer index does not move. A status that still reads 0 becomes 9 (overflow).
- R5: A doorbell acts only when bits QN_W-1:0 of word 0 equal Q_ID and bits 31:24 hold a command code from 1 to 5. Any other doorbell changes nothing.
- R6: Command 1 advances the consumer index by one. It is ignored when no entry is outstanding.
- R7: Command 4 moves the consumer index to word 1 masked by DEPTH-1. It is ignored when the forward distance to that value exceeds the number of outstanding entries.
- R8: Command 2 sets the notification state to armed (1). An accepted event in the armed state gives a one-cycle `irq_o` pulse, in the same cycle as its `mem_we_o`, and moves the state to fired (2). Further events raise no interrupt until the next command 2. State 0 means disarmed.
- R9: Command 5 sets the state to always armed (3). In that state every accepted event pulses `irq_o` and the state does not change.
- R10: Command 3 pulses `cq_disarm_vld_o` for one cycle in the following cycle, with `cq_disarm_num_o` equal to bits 23:0 of word 1. It has no other effect.
- R11: Once the status is non-zero it keeps its first error code until reset, whatever faults follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event request, one per cycle |
| evt_type_i | input | 8 | Event type |
| evt_subtype_i | input | 8 | Event subtype |
| evt_payload_i | input | 192 | Event payload, 24 bytes |
| own_i | input | 1 | Ownership flag of the slot at `prod_idx_o` (1 = hardware) |
| db_valid_i | input | 1 | Doorbell write strobe |
| db_word0_i | input | 32 | Doorbell command (31:24) and queue number (low bits) |
| db_word1_i | input | 32 | Doorbell argument |
| mem_we_o | output | 1 | Entry write strobe |
| mem_addr_o | output | IDX_W+5 | Byte address of the entry |
| mem_wdata_o | output | 256 | Full entry contents |
| irq_o | output | 1 | Interrupt pulse |
| cq_disarm_vld_o | output | 1 | Completion-queue disarm request |
| cq_disarm_num_o | output | 24 | Completion-queue number to disarm |
| status_o | output | 4 | 0 ok, 9 overflow, 10 write failure |
| prod_idx_o | output | IDX_W | Producer slot index |
| cons_idx_o | output | IDX_W | Consumer slot index |
| arm_state_o | output | 2 | 0 disarmed, 1 armed, 2 fired, 3 always armed |

## Verification
The assertions assume that `own_i` reflects the slot at the current producer index and is stable within a cycle. They also assume that the consumer index moves only in response to doorbells. The stimulus drives `own_i` from a bench ownership array indexed by `prod_idx_o`, and it changes that array only between clock edges. Software consumption is modelled by setting slots back to hardware ownership before the matching doorbell. For the write-failure case that restore is deliberately skipped.

// File: rtl/eqp_pkg.sv
package eqp_pkg;
  localparam int ENTRY_W   = 256;
  localparam int PAYLOAD_W = 192;

  typedef enum logic [1:0] {
    NS_IDLE   = 2'd0,
    NS_ARMED  = 2'd1,
    NS_FIRED  = 2'd2,
    NS_ALWAYS = 2'd3
  } ntf_state_e;

  localparam logic [7:0] DB_INC_CI  = 8'd1;
  localparam logic [7:0] DB_ARM     = 8'd2;
  localparam logic [7:0] DB_CQ_OFF  = 8'd3;
  localparam logic [7:0] DB_SET_CI  = 8'd4;
  localparam logic [7:0] DB_ARM_ALL = 8'd5;

  localparam logic [3:0] ST_OK    = 4'd0;
  localparam logic [3:0] ST_OVF   = 4'd9;
  localparam logic [3:0] ST_WFAIL = 4'd10;
endpackage

// File: rtl/eqp_doorbell.sv
module eqp_doorbell #(
  parameter int QN_W  = 5,
  parameter int Q_ID  = 3,
  parameter int IDX_W = 3
) (
  input  logic             db_valid_i,
  input  logic [31:0]      db_w0_i,
  input  logic [31:0]      db_w1_i,
  output logic             inc_ci_o,
  output logic             set_ci_o,
  output logic [IDX_W-1:0] set_val_o,
  output logic             arm_o,
  output logic             arm_always_o,
  output logic             cq_off_o,
  output logic [23:0]      cq_num_o
);
  import eqp_pkg::*;

  logic       hit;
  logic [7:0] cmd;

  assign hit = db_valid_i && (db_w0_i[QN_W-1:0] == QN_W'(Q_ID));
  assign cmd = db_w0_i[31:24];

  assign inc_ci_o     = hit && (cmd == DB_INC_CI);
  assign set_ci_o     = hit && (cmd == DB_SET_CI);
  assign arm_o        = hit && (cmd == DB_ARM);
  assign arm_always_o = hit && (cmd == DB_ARM_ALL);
  assign cq_off_o     = hit && (cmd == DB_CQ_OFF);
  assign set_val_o    = db_w1_i[IDX_W-1:0];
  assign cq_num_o     = db_w1_i[23:0];
endmodule

// File: rtl/eqp_index.sv
module eqp_index #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_try_i,
  input  logic             own_i,
  input  logic             inc_ci_i,
  input  logic             set_ci_i,
  input  logic [IDX_W-1:0] set_val_i,
  output logic             accept_o,
  output logic             ovf_o,
  output logic             wfail_o,
  output logic [IDX_W-1:0] prod_o,
  output logic [IDX_W-1:0] cons_o,
  output logic [IDX_W:0]   fill_o
);
  logic [IDX_W-1:0] prod_q, cons_q, set_dist;
  logic [IDX_W:0]   fill_q, adv;
  logic             full;

  assign full     = (fill_q == (IDX_W+1)'(DEPTH));
  assign accept_o = evt_try_i && !full && own_i;
  assign ovf_o    = evt_try_i && full;
  assign wfail_o  = evt_try_i && !full && !own_i;
  assign set_dist = set_val_i - cons_q;

  // release may never pass the producer
  always_comb begin
    adv = '0;
    if (inc_ci_i && (fill_q != '0))
      adv = (IDX_W+1)'(1);
    else if (set_ci_i && ({1'b0, set_dist} <= fill_q))
      adv = {1'b0, set_dist};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      cons_q <= '0;
      fill_q <= '0;
    end else begin
      prod_q <= prod_q + IDX_W'(accept_o);
      cons_q <= cons_q + adv[IDX_W-1:0];
      fill_q <= fill_q + (IDX_W+1)'(accept_o) - adv;
    end
  end

  assign prod_o = prod_q;
  assign cons_o = cons_q;
  assign fill_o = fill_q;
endmodule

// File: rtl/eqp_notify.sv
module eqp_notify (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       arm_i,
  input  logic       arm_always_i,
  output logic       fire_o,
  output logic [1:0] state_o
);
  import eqp_pkg::*;

  ntf_state_e state_q, state_d;

  always_comb begin
    fire_o  = accept_i && (state_q == NS_ARMED || state_q == NS_ALWAYS);
    state_d = state_q;
    if (accept_i && state_q == NS_ARMED) state_d = NS_FIRED;
    if (arm_i)             state_d = NS_ARMED;
    else if (arm_always_i) state_d = NS_ALWAYS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= NS_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/eq_producer.sv
module eq_producer #(
  parameter int DEPTH = 8,
  parameter int QN_W  = 5,
  parameter int Q_ID  = 3,
  localparam int IDX_W  = (DEPTH > 2) ? $clog2(DEPTH) : 1,
  localparam int ADDR_W = IDX_W + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [7:0]        evt_type_i,
  input  logic [7:0]        evt_subtype_i,
  input  logic [191:0]      evt_payload_i,
  input  logic              own_i,
  input  logic              db_valid_i,
  input  logic [31:0]       db_word0_i,
  input  logic [31:0]       db_word1_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [255:0]      mem_wdata_o,
  output logic              irq_o,
  output logic              cq_disarm_vld_o,
  output logic [23:0]       cq_disarm_num_o,
  output logic [3:0]        status_o,
  output logic [IDX_W-1:0]  prod_idx_o,
  output logic [IDX_W-1:0]  cons_idx_o,
  output logic [1:0]        arm_state_o
);
  import eqp_pkg::*;

  logic             inc_ci, set_ci, arm, arm_always, cq_off;
  logic [IDX_W-1:0] set_val, prod, cons;
  logic [23:0]      cq_num;
  logic             accept, ovf, wfail, fire;
  logic [IDX_W:0]   fill;

  eqp_doorbell #(.QN_W(QN_W), .Q_ID(Q_ID), .IDX_W(IDX_W)) i_db (
    .db_valid_i   (db_valid_i),
    .db_w0_i      (db_word0_i),
    .db_w1_i      (db_word1_i),
    .inc_ci_o     (inc_ci),
    .set_ci_o     (set_ci),
    .set_val_o    (set_val),
    .arm_o        (arm),
    .arm_always_o (arm_always),
    .cq_off_o     (cq_off),
    .cq_num_o     (cq_num)
  );

  eqp_index #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_idx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_try_i (evt_valid_i),
    .own_i     (own_i),
    .inc_ci_i  (inc_ci),
    .set_ci_i  (set_ci),
    .set_val_i (set_val),
    .accept_o  (accept),
    .ovf_o     (ovf),
    .wfail_o   (wfail),
    .prod_o    (prod),
    .cons_o    (cons),
    .fill_o    (fill)
  );

  eqp_notify i_ntf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .arm_i        (arm),
    .arm_always_i (arm_always),
    .fire_o       (fire),
    .state_o      (arm_state_o)
  );

  logic [255:0] entry;
  assign entry = {8'h00, 24'h0, evt_payload_i, evt_subtype_i, 8'h00, evt_type_i, 8'h00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o        <= 1'b0;
      mem_addr_o      <= '0;
      mem_wdata_o     <= '0;
      irq_o           <= 1'b0;
      cq_disarm_vld_o <= 1'b0;
      cq_disarm_num_o <= '0;
      status_o        <= ST_OK;
    end else begin
      mem_we_o        <= accept;
      irq_o           <= fire;
      cq_disarm_vld_o <= cq_off;
      if (accept) begin
        mem_addr_o  <= {prod, 5'b0};
        mem_wdata_o <= entry;
      end
      if (cq_off) cq_disarm_num_o <= cq_num;
      // first fault wins
      if (status_o == ST_OK) begin
        if (ovf)        status_o <= ST_OVF;
        else if (wfail) status_o <= ST_WFAIL;
      end
    end
  end

  assign prod_idx_o = prod;
  assign cons_idx_o = cons;
endmodule

// File: rtl/eq_producer_chk.sv
module eq_producer_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt_valid_i,
  input logic             own_i,
  input logic             db_valid_i,
  input logic             mem_we_o,
  input logic [255:0]     mem_wdata_o,
  input logic [IDX_W+4:0] mem_addr_o,
  input logic             irq_o,
  input logic             cq_disarm_vld_o,
  input logic [3:0]       status_o,
  input logic [IDX_W-1:0] prod_idx_o,
  input logic [IDX_W-1:0] cons_idx_o,
  input logic [1:0]       arm_state_o,
  input logic [IDX_W:0]   fill_i
);
  // R2
  owner_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o[255] == 1'b0 && mem_addr_o[4:0] == 5'd0));

  // R3
  sw_owned_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !own_i) |=> (!mem_we_o && $stable(prod_idx_o)));

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && fill_i == (IDX_W+1)'(DEPTH)) |=> (!mem_we_o && $stable(prod_idx_o)));

  // R6
  cons_by_doorbell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !db_valid_i |=> $stable(cons_idx_o));

  // R8
  irq_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mem_we_o && ($past(arm_state_o) == 2'd1 || $past(arm_state_o) == 2'd3)));

  // R10
  disarm_from_db_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cq_disarm_vld_o |-> $past(db_valid_i));

  // R11
  sticky_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 4'd0) |=> $stable(status_o));
endmodule

bind eq_producer eq_producer_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .evt_valid_i     (evt_valid_i),
  .own_i           (own_i),
  .db_valid_i      (db_valid_i),
  .mem_we_o        (mem_we_o),
  .mem_wdata_o     (mem_wdata_o),
  .mem_addr_o      (mem_addr_o),
  .irq_o           (irq_o),
  .cq_disarm_vld_o (cq_disarm_vld_o),
  .status_o        (status_o),
  .prod_idx_o      (prod_idx_o),
  .cons_idx_o      (cons_idx_o),
  .arm_state_o     (arm_state_o),
  .fill_i          (fill)
);

// File: tb/test_eq_producer.sv
module test_eq_producer;
  localparam int D    = 8;
  localparam int QID  = 3;
  localparam int IW   = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic evt_valid = 1'b0;
  logic [7:0] evt_type = '0, evt_sub = '0;
  logic [191:0] evt_pay = '0;
  logic own;
  logic db_valid = 1'b0;
  logic [31:0] db_w0 = '0, db_w1 = '0;
  logic mem_we, irq, dis_vld;
  logic [IW+4:0] mem_addr;
  logic [255:0] mem_wdata;
  logic [23:0] dis_num;
  logic [3:0] status;
  logic [IW-1:0] prod_idx, cons_idx;
  logic [1:0] arm_state;

  logic owner [D];
  assign own = owner[prod_idx];

  always #2.5 clk = ~clk;

  eq_producer #(.DEPTH(D), .QN_W(5), .Q_ID(QID)) i_eq_producer (
    .clk_i(clk), .rst_ni(rst_ni), .evt_valid_i(evt_valid), .evt_type_i(evt_type),
    .evt_subtype_i(evt_sub), .evt_payload_i(evt_pay), .own_i(own),
    .db_valid_i(db_valid), .db_word0_i(db_w0), .db_word1_i(db_w1),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .irq_o(irq),
    .cq_disarm_vld_o(dis_vld), .cq_disarm_num_o(dis_num), .status_o(status),
    .prod_idx_o(prod_idx), .cons_idx_o(cons_idx), .arm_state_o(arm_state)
  );

  int checks = 0, errors = 0;
  string tag = "R1";
  int m_prod, m_cons, m_fill, m_state, m_status;
  bit e_we, e_irq, e_dv;
  int e_addr, e_dnum;
  logic [255:0] e_data;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_data();
    checks++;
    if (mem_wdata !== e_data) begin
      errors++;
      $display("FAIL %s entry: actual %0h expected %0h", tag, mem_wdata, e_data);
    end
  endtask

  task automatic compare_all();
    chk("prod", prod_idx, m_prod);
    chk("cons", cons_idx, m_cons);
    chk("state", arm_state, m_state);
    chk("status", status, m_status);
    chk("we", mem_we, e_we);
    chk("irq", irq, e_irq);
    chk("disarm_vld", dis_vld, e_dv);
    if (e_we) begin
      chk("addr", mem_addr, e_addr);
      chk_data();
    end
    if (e_dv) chk("disarm_num", dis_num, e_dnum);
  endtask

  task automatic model_reset();
    m_prod = 0; m_cons = 0; m_fill = 0; m_state = 0; m_status = 0;
    e_we = 0; e_irq = 0; e_dv = 0;
    for (int i = 0; i < D; i++) owner[i] = 1'b1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // one cycle: drive at negedge, advance model, compare at next negedge
  task automatic cyc(bit ev, int typ, int sub, logic [191:0] pay, bit db, int cmd, int qn, int w1);
    bit acc, full, ow;
    int adv, a, ns;
    evt_valid = ev; evt_type = 8'(typ); evt_sub = 8'(sub); evt_pay = pay;
    db_valid = db; db_w0 = {8'(cmd), 19'd0, 5'(qn)}; db_w1 = 32'(w1);
    full = (m_fill == D);
    ow = owner[m_prod];
    acc = ev && !full && ow;
    e_we = acc;
    e_addr = m_prod * 32;
    e_data = '0;
    e_data[8 +: 8]  = 8'(typ);
    e_data[24 +: 8] = 8'(sub);
    for (int b = 0; b < 24; b++) e_data[32 + 8*b +: 8] = pay[8*b +: 8];
    e_irq = acc && (m_state == 1 || m_state == 3);
    adv = 0;
    ns = m_state;
    if (e_irq && m_state == 1) ns = 2;
    e_dv = 0;
    if (db && qn == QID) begin
      if (cmd == 1 && m_fill >= 1) adv = 1;
      if (cmd == 4) begin
        a = ((w1 % D) - m_cons + D) % D;
        if (a <= m_fill) adv = a;
      end
      if (cmd == 2) ns = 1;
      if (cmd == 5) ns = 3;
      if (cmd == 3) begin e_dv = 1; e_dnum = w1 & 32'hFFFFFF; end
    end
    if (m_status == 0) begin
      if (ev && full) m_status = 9;
      else if (ev && !ow) m_status = 10;
    end
    @(posedge clk);
    @(negedge clk);
    if (acc) owner[m_prod] = 1'b0;
    m_prod = (m_prod + int'(acc)) % D;
    m_cons = (m_cons + adv) % D;
    m_fill = m_fill + int'(acc) - adv;
    m_state = ns;
    compare_all();
    evt_valid = 1'b0; db_valid = 1'b0;
  endtask

  task automatic ev(int typ, int sub);
    cyc(1, typ, sub, {6{32'(typ * 32'h01010101 + sub)}}, 0, 0, 0, 0);
  endtask

  task automatic dbl(int cmd, int qn, int w1);
    cyc(0, 0, 0, '0, 1, cmd, qn, w1);
  endtask

  task automatic idle();
    cyc(0, 0, 0, '0, 0, 0, 0, 0);
  endtask

  // software frees entries and hands them back to hardware
  task automatic sw_consume(int n, bit restore);
    for (int i = 0; i < n; i++) begin
      if (restore) owner[m_cons] = 1'b1;
      dbl(1, QID, 0);
    end
  endtask

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    tag = "R1"; compare_all();

    tag = "R2"; ev(8'h11, 8'h04); ev(8'h22, 8'h00); ev(8'h0a, 8'hff); idle();
    tag = "R8"; dbl(2, QID, 0); ev(8'h01, 8'h01); ev(8'h02, 8'h02);
    dbl(2, QID, 0); ev(8'h03, 8'h03);
    tag = "R5"; dbl(5, QID + 1, 0); dbl(7, QID, 0); dbl(1, 4, 0); ev(8'h04, 8'h04);
    tag = "R9"; dbl(5, QID, 0); ev(8'h05, 8'h05);
    tag = "R4"; ev(8'h06, 8'h06); ev(8'h07, 8'h07); idle();
    tag = "R11"; sw_consume(1, 0); ev(8'h08, 8'h08); idle();
    tag = "R4"; sw_consume(2, 1); ev(8'h09, 8'h09); ev(8'h0b, 8'h0b);

    do_reset();
    tag = "R1"; compare_all();
    tag = "R3"; ev(8'h10, 1); ev(8'h12, 2);
    sw_consume(2, 0); ev(8'h13, 3); ev(8'h14, 4);
    tag = "R6"; dbl(1, QID, 0); dbl(1, QID, 0);
    tag = "R7"; do_reset();
    ev(1, 1); ev(2, 2); ev(3, 3); ev(4, 4);
    dbl(4, QID, 32'h0000_0022); dbl(4, QID, 6); dbl(4, QID, 1); dbl(4, QID, 4);
    for (int i = 0; i < 6; i++) begin owner[(m_prod) % D] = 1'b1; ev(16 + i, i); end
    dbl(4, QID, 2);
    tag = "R10"; dbl(3, QID, 32'h7_abcdef); dbl(3, QID + 2, 5); idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule